// File: doc/BRIEF.md
# BCD Calendar Clock Register Core

This block keeps calendar time in packed BCD. The fields are hundredths, seconds, minutes, hours (24-hour), day of week, date, month and year. Counting advances on a 100 Hz tick enable while an oscillator-present input is high and a stop control is clear. Carries ripple from the hundredths through to the year within the same clock. Date rollover follows the length of each month, including leap Februaries.

Software reaches the fields through a byte-wide port with a write strobe, an address, write data and a combinational read. The core also holds a stop control and a century enable with a century bit that flips on each year rollover. It keeps a sticky oscillator-fail flag, which can be seen and cleared at two addresses.

Top module: `rtc_bcd_core`

## Requirements
- R1: Seconds and minutes count 00 to 59, hours 00 to 23 and hundredths 00 to 99, all in packed BCD. Each field wraps to 00 and carries one into the next field.
- R2: Register addresses are 00h seconds, 01h minutes, 02h hours, 03h day of week, 04h date, 05h month and 06h year. Unused addresses read 00h, and 07h reads the constant 80h.
- R3: Address 1Fh reads the hundredths count, and writes to 1Fh change nothing.
- R4: Bit 7 of 00h is the stop control. While it is 1, no field advances, and the oscillator-fail flag is set on the following clock.
- R5: Bit 7 of 01h is the oscillator-fail flag. It is set on every clock where the oscillator-present input is low. A write with bit 7 = 0 clears it only when oscillation is present and stop is 0. A write with bit 7 = 1 leaves it unchanged.
- R6: Bit 7 of 09h is the same fail flag, and the other bits of 09h read 0. A write to 09h with bit 7 = 0 clears the flag under the rules of R5 and alters no time field.
- R7: Bit 7 of 02h is century enable and bit 6 is the century bit. When enable is 1, the century bit inverts as the year wraps from 99 to 00. When enable is 0, the century bit holds.
- R8: Day of week (3 bits) advances once per date change in the order 1,2,...,7,1, independently of the date value.
- R9: The date wraps to 01 after 31, or after 30 in April, June, September and November. In February it wraps after 28, or after 29 when the BCD year is divisible by 4.
- R10: Month wraps from 12 to 01 and carries one into the year. The year wraps from 99 to 00.
- R11: Counting advances only on clocks where the tick enable is high, stop is 0 and the oscillator-present input is high.
- R12: A write to any address 00h to 06h forces the hundredths to 00, and no carry propagates on that clock.
- R13: Reserved bits read 0 whatever is written: date bits 7:6, month bits 7:5 and day-of-week bits 7:3.
- R14: After reset every time field and control bit is 0, the fail flag is 1, and 01h, 07h and 09h read 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz | input | 1 | One-clock enable at 100 Hz |
| osc_ok | input | 1 | High while the oscillator is running |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The bench drives a full carry from 23:59:59.99 on 31 December 99. A design that skipped the century toggle, or toggled it with enable clear, would show the wrong bit 6 at 02h. February is run in a leap year and in a common year, and April is run to its 30th. A wrong month-length table would land on 29 Feb, 30 Feb or 31 Apr. The fail flag is written to 1, and cleared with oscillation absent, through both of its addresses. A flag that was writable, or that cleared while the oscillator was down, would read 0 too early. Writes to 1Fh and to reserved bits check that a read-only count stays put and that masked bits do not leak into the stored fields.

// File: rtl/rtc_pkg.sv
// Package: shared constants and field descriptors for the BCD calendar core.
// Assumes: 8-bit register bytes and a 5-bit register address.
package rtc_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int NFIELD  = 8;

    localparam logic [ADDR_W-1:0] ADDR_SEC  = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_MIN  = 5'h01;
    localparam logic [ADDR_W-1:0] ADDR_HOUR = 5'h02;
    localparam logic [ADDR_W-1:0] ADDR_DOW  = 5'h03;
    localparam logic [ADDR_W-1:0] ADDR_DATE = 5'h04;
    localparam logic [ADDR_W-1:0] ADDR_MON  = 5'h05;
    localparam logic [ADDR_W-1:0] ADDR_YEAR = 5'h06;
    localparam logic [ADDR_W-1:0] ADDR_CONST = 5'h07;
    localparam logic [ADDR_W-1:0] ADDR_FAIL = 5'h09;
    localparam logic [ADDR_W-1:0] ADDR_HUND = 5'h1F;

    // Field index order; carries run along this chain
    localparam int F_HUND = 0;
    localparam int F_SEC  = 1;
    localparam int F_MIN  = 2;
    localparam int F_HOUR = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;
    localparam int F_DOW  = 7;

    localparam logic [BYTE_W-1:0] CONST_REG_VAL = 8'h80;

    // Lowest value a field wraps back to
    function automatic logic [BYTE_W-1:0] field_min(input int idx);
        case (idx)
            F_DATE, F_MON, F_DOW: return 8'h01;
            default:              return 8'h00;
        endcase
    endfunction

    // Fixed top value of a field (date uses the month length instead)
    function automatic logic [BYTE_W-1:0] field_max(input int idx);
        case (idx)
            F_HUND:  return 8'h99;
            F_SEC:   return 8'h59;
            F_MIN:   return 8'h59;
            F_HOUR:  return 8'h23;
            F_DATE:  return 8'h31;
            F_MON:   return 8'h12;
            F_YEAR:  return 8'h99;
            default: return 8'h07;
        endcase
    endfunction

    // Bits of a written byte that are kept in the field
    function automatic logic [BYTE_W-1:0] field_mask(input int idx);
        case (idx)
            F_HUND:  return 8'h00;
            F_SEC:   return 8'h7F;
            F_MIN:   return 8'h7F;
            F_HOUR:  return 8'h3F;
            F_DATE:  return 8'h3F;
            F_MON:   return 8'h1F;
            F_YEAR:  return 8'hFF;
            default: return 8'h07;
        endcase
    endfunction

    // Address that loads a field (hundredths is never loaded by address)
    function automatic logic [ADDR_W-1:0] field_addr(input int idx);
        case (idx)
            F_SEC:   return ADDR_SEC;
            F_MIN:   return ADDR_MIN;
            F_HOUR:  return ADDR_HOUR;
            F_DATE:  return ADDR_DATE;
            F_MON:   return ADDR_MON;
            F_YEAR:  return ADDR_YEAR;
            F_DOW:   return ADDR_DOW;
            default: return ADDR_HUND;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_counter.sv
// Module: one packed-BCD field counter with load, increment and wrap-out.
// Assumes: W is a multiple of 4 and stored values are valid BCD; a value at
// or above max_val wraps to MIN_VAL on the next increment. A load wins over
// an increment and suppresses the wrap output on that clock.
module rtc_bcd_counter #(
    parameter int          W       = 8,
    parameter logic [W-1:0] MIN_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic [W-1:0] max_val,
    output logic [W-1:0] q,
    output logic         wrap
);

    localparam int NDIG = W / 4;

    // Add one to a packed BCD number, digit by digit
    function automatic logic [W-1:0] bcd_plus1(input logic [W-1:0] v);
        logic [W-1:0] r;
        logic         c;
        r = v;
        c = 1'b1;
        for (int n = 0; n < NDIG; n++) begin
            if (c) begin
                if (v[n*4 +: 4] == 4'd9) begin
                    r[n*4 +: 4] = 4'd0;
                end else begin
                    r[n*4 +: 4] = v[n*4 +: 4] + 4'd1;
                    c = 1'b0;
                end
            end
        end
        return r;
    endfunction

    logic at_top;

    // Detect the wrap point and emit the carry for the next field
    always_comb begin
        at_top = (q >= max_val);
        wrap   = inc && !load && at_top;
    end

    // Field register: reset, load, wrap or step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (inc) begin
            q <= at_top ? MIN_VAL : bcd_plus1(q);
        end
    end

endmodule

// File: rtl/rtc_month_len.sv
// Module: last valid date of the current month, in BCD.
// Assumes: month and year hold valid BCD; leap years are BCD years whose
// binary value is a multiple of four.
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [BYTE_W-1:0] month,
    input  logic [BYTE_W-1:0] year,
    output logic [BYTE_W-1:0] last_day
);

    logic [6:0] year_bin;
    logic       leap;

    // Convert the BCD year and test divisibility by four
    always_comb begin
        year_bin = 7'({3'b000, year[7:4]} * 7'd10) + {3'b000, year[3:0]};
        leap     = (year_bin[1:0] == 2'b00);
    end

    // Pick the month length
    always_comb begin
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_ctrl_bits.sv
// Module: stop control, century enable/bit and the sticky oscillator-fail flag.
// Assumes: the flag set condition (no oscillation or stop) beats a clear
// write on the same clock; year_wrap is the single-cycle year 99->00 carry.
module rtc_ctrl_bits
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_ok,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        wdata_hi,
    input  logic              year_wrap,
    output logic              stop,
    output logic              ofail,
    output logic              cen,
    output logic              cbit
);

    logic fail_set;
    logic fail_clr;

    // Decode set and clear requests for the fail flag
    always_comb begin
        fail_set = !osc_ok || stop;
        fail_clr = wr_en && !wdata_hi[1] && (addr == ADDR_MIN || addr == ADDR_FAIL);
    end

    // Stop control, loaded from bit 7 of the seconds byte
    always_ff @(posedge clk) begin
        if (!rst_n)                             stop <= 1'b0;
        else if (wr_en && addr == ADDR_SEC)     stop <= wdata_hi[1];
    end

    // Sticky fail flag: set wins, clear only by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n)        ofail <= 1'b1;
        else if (fail_set) ofail <= 1'b1;
        else if (fail_clr) ofail <= 1'b0;
    end

    // Century enable and century bit, with toggle on year rollover
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen  <= 1'b0;
            cbit <= 1'b0;
        end else if (wr_en && addr == ADDR_HOUR) begin
            cen  <= wdata_hi[1];
            cbit <= wdata_hi[0];
        end else if (year_wrap && cen) begin
            cbit <= !cbit;
        end
    end

endmodule

// File: rtl/rtc_bcd_core.sv
// Module: top of the BCD calendar core: field counters, carry chain,
// control bits and the combinational read mux.
// Assumes: single-cycle writes; a write to 00h..06h zeroes the hundredths
// and blocks every carry on that clock.
module rtc_bcd_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              osc_ok,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] fq    [NFIELD];
    logic              fwrap [NFIELD];
    logic              finc  [NFIELD];
    logic [BYTE_W-1:0] date_last;
    logic              time_wr;
    logic              count_go;
    logic              stop_q;
    logic              ofail_q;
    logic              cen_q;
    logic              cbit_q;
    logic [BYTE_W-1:0] hund_q;
    logic [BYTE_W-1:0] dow_q;

    // Global advance and time-write qualifiers
    always_comb begin
        time_wr  = wr_en && (addr <= ADDR_YEAR);
        count_go = tick_100hz && !stop_q && osc_ok;
    end

    assign hund_q = fq[F_HUND];
    assign dow_q  = fq[F_DOW];

    rtc_month_len u_mlen (
        .month    (fq[F_MON]),
        .year     (fq[F_YEAR]),
        .last_day (date_last)
    );

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        localparam logic [BYTE_W-1:0] FMIN  = field_min(i);
        localparam logic [BYTE_W-1:0] FMASK = field_mask(i);
        localparam logic [ADDR_W-1:0] FADDR = field_addr(i);
        logic              ld;
        logic [BYTE_W-1:0] cmax;

        if (i == F_HUND) begin : g_ld_h
            assign ld = time_wr;
        end else begin : g_ld_a
            assign ld = wr_en && (addr == FADDR);
        end

        if (i == F_DATE) begin : g_max_d
            assign cmax = date_last;
        end else begin : g_max_f
            assign cmax = field_max(i);
        end

        if (i == F_HUND) begin : g_inc_h
            assign finc[i] = count_go;
        end else if (i == F_DATE || i == F_DOW) begin : g_inc_d
            assign finc[i] = fwrap[F_HOUR];
        end else if (i == F_MON) begin : g_inc_m
            assign finc[i] = fwrap[F_DATE];
        end else if (i == F_YEAR) begin : g_inc_y
            assign finc[i] = fwrap[F_MON];
        end else begin : g_inc_c
            assign finc[i] = fwrap[i-1];
        end

        rtc_bcd_counter #(
            .W       (BYTE_W),
            .MIN_VAL (FMIN)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld),
            .load_val (wdata & FMASK),
            .inc      (finc[i]),
            .max_val  (cmax),
            .q        (fq[i]),
            .wrap     (fwrap[i])
        );
    end

    rtc_ctrl_bits u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_ok    (osc_ok),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata_hi  (wdata[7:6]),
        .year_wrap (fwrap[F_YEAR]),
        .stop      (stop_q),
        .ofail     (ofail_q),
        .cen       (cen_q),
        .cbit      (cbit_q)
    );

    // Read mux by address
    always_comb begin
        case (addr)
            ADDR_SEC:   rdata = {stop_q, fq[F_SEC][6:0]};
            ADDR_MIN:   rdata = {ofail_q, fq[F_MIN][6:0]};
            ADDR_HOUR:  rdata = {cen_q, cbit_q, fq[F_HOUR][5:0]};
            ADDR_DOW:   rdata = {5'b0, dow_q[2:0]};
            ADDR_DATE:  rdata = {2'b0, fq[F_DATE][5:0]};
            ADDR_MON:   rdata = {3'b0, fq[F_MON][4:0]};
            ADDR_YEAR:  rdata = fq[F_YEAR];
            ADDR_CONST: rdata = CONST_REG_VAL;
            ADDR_FAIL:  rdata = {ofail_q, 7'b0};
            ADDR_HUND:  rdata = hund_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_core_chk.sv
// Module: property checker for the BCD calendar core, bound to the top.
// Assumes: synchronous active-low reset; all properties are disabled in reset.
module rtc_bcd_core_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_100hz,
    input logic              osc_ok,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] rdata,
    input logic [BYTE_W-1:0] hund,
    input logic [BYTE_W-1:0] dow,
    input logic              stop,
    input logic              ofail,
    input logic              cen,
    input logic              cbit
);

    assert_hund_bcd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hund[3:0] <= 4'd9) && (hund[7:4] <= 4'd9));

    assert_stop_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !wr_en) |=> $stable(hund));

    assert_fail_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_ok || stop) |=> ofail);

    assert_century_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen && !wr_en) |=> $stable(cbit));

    assert_dow_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dow <= 8'd7);

    assert_no_tick_no_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_100hz && osc_ok) && !wr_en) |=> $stable(hund));

    assert_date_zero_bits_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_DATE) |-> (rdata[7:6] == 2'b00));

endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_100hz (tick_100hz),
    .osc_ok     (osc_ok),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .hund       (hund_q),
    .dow        (dow_q),
    .stop       (stop_q),
    .ofail      (ofail_q),
    .cen        (cen_q),
    .cbit       (cbit_q)
);

// File: tb/rtc_bcd_core_tb_top.sv
// Bench: behavioural integer model of the calendar, compared every clock.
module rtc_bcd_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       osc_ok = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state, plain integers
    int m_hund, m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year;
    bit m_stop, m_fail, m_cen, m_cb;

    always #5 clk = ~clk;

    rtc_bcd_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_100hz (tick_100hz),
        .osc_ok     (osc_ok),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata)
    );

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_of(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] model_read(input logic [4:0] a);
        case (a)
            5'h00: return {m_stop, 7'(i2b(m_sec))};
            5'h01: return {m_fail, 7'(i2b(m_min))};
            5'h02: return {m_cen, m_cb, 6'(i2b(m_hour))};
            5'h03: return 8'(m_dow);
            5'h04: return i2b(m_date);
            5'h05: return i2b(m_mon);
            5'h06: return i2b(m_year);
            5'h07: return 8'h80;
            5'h09: return {m_fail, 7'b0};
            5'h1F: return i2b(m_hund);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_hund = 0; m_sec = 0; m_min = 0; m_hour = 0;
        m_dow = 0; m_date = 0; m_mon = 0; m_year = 0;
        m_stop = 0; m_fail = 1; m_cen = 0; m_cb = 0;
    endtask

    task automatic model_clock(input bit we, input logic [4:0] a, input logic [7:0] d,
                               input bit tk, input bit osc);
        bit old_stop = m_stop;
        bit go = tk && !old_stop && osc;
        if (!osc || old_stop) m_fail = 1;
        else if (we && (a == 5'h01 || a == 5'h09) && !d[7]) m_fail = 0;
        if (we && a <= 5'h06) begin
            m_hund = 0;
            case (a)
                5'h00: begin m_stop = d[7]; m_sec = b2i(d & 8'h7F); end
                5'h01: m_min = b2i(d & 8'h7F);
                5'h02: begin m_cen = d[7]; m_cb = d[6]; m_hour = b2i(d & 8'h3F); end
                5'h03: m_dow = int'(d & 8'h07);
                5'h04: m_date = b2i(d & 8'h3F);
                5'h05: m_mon = b2i(d & 8'h1F);
                default: m_year = b2i(d);
            endcase
        end else if (go) begin
            if (m_hund >= 99) begin
                m_hund = 0;
                if (m_sec >= 59) begin
                    m_sec = 0;
                    if (m_min >= 59) begin
                        m_min = 0;
                        if (m_hour >= 23) begin
                            m_hour = 0;
                            m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
                            if (m_date >= days_of(m_mon, m_year)) begin
                                m_date = 1;
                                if (m_mon >= 12) begin
                                    m_mon = 1;
                                    if (m_year >= 99) begin
                                        m_year = 0;
                                        if (m_cen) m_cb = !m_cb;
                                    end else m_year++;
                                end else m_mon++;
                            end else m_date++;
                        end else m_hour++;
                    end else m_min++;
                end else m_sec++;
            end else m_hund++;
        end
    endtask

    // One clock: drive, compare the read of addr, then advance the model
    task automatic step(input string tag, input bit we, input logic [4:0] a,
                        input logic [7:0] d, input bit tk, input bit osc);
        logic [7:0] exp;
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; tick_100hz = tk; osc_ok = osc;
        #2;
        exp = model_read(a);
        n_chk++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
        end
        @(posedge clk);
        model_clock(we, a, d, tk, osc);
    endtask

    task automatic wr(input string tag, input logic [4:0] a, input logic [7:0] d);
        step(tag, 1'b1, a, d, 1'b0, 1'b1);
    endtask

    task automatic rd(input string tag, input logic [4:0] a);
        step(tag, 1'b0, a, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic ticks(input string tag, input int n, input logic [4:0] a);
        for (int k = 0; k < n; k++) step(tag, 1'b0, a, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic read_all(input string tag);
        for (int k = 0; k < 8; k++) rd(tag, 5'(k));
        rd(tag, 5'h09);
        rd(tag, 5'h1F);
    endtask

    // Load a full time stamp just before midnight and run over it
    task automatic midnight(input string tag, input logic [7:0] hr, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(tag, 5'h06, yr);
        wr(tag, 5'h05, mo);
        wr(tag, 5'h04, dt);
        wr(tag, 5'h02, hr);
        wr(tag, 5'h01, 8'h59);
        wr(tag, 5'h00, 8'h59);
        ticks(tag, 100, 5'h1F);
        read_all(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R14: reset values, and R2 constant at 07h
        read_all("R14");
        // R1, R11: plain counting past a seconds and minute carry
        ticks("R1", 250, 5'h1F);
        rd("R1", 5'h00);
        wr("R1", 5'h00, 8'h59);
        ticks("R1", 100, 5'h00);
        read_all("R1");
        // R11: tick without oscillation does nothing, and sets the flag
        for (int k = 0; k < 20; k++) step("R11", 1'b0, 5'h1F, 8'h00, 1'b1, 1'b0);
        ticks("R11", 5, 5'h01);
        // R5: clear the flag, then writing 1 has no effect
        wr("R5", 5'h01, 8'h05);
        rd("R5", 5'h01);
        wr("R5", 5'h01, 8'h87);
        rd("R5", 5'h01);
        // R5: clear attempt while oscillation is absent
        step("R5", 1'b1, 5'h01, 8'h00, 1'b0, 1'b0);
        rd("R5", 5'h01);
        // R6: second view clears and reads the flag
        wr("R6", 5'h09, 8'h00);
        rd("R6", 5'h09);
        rd("R6", 5'h01);
        wr("R6", 5'h09, 8'hFF);
        read_all("R6");
        // R4: stop halts and sets the flag; a clear attempt under stop fails
        wr("R4", 5'h00, 8'h80 | 8'h12);
        ticks("R4", 30, 5'h1F);
        wr("R4", 5'h09, 8'h00);
        rd("R4", 5'h01);
        wr("R4", 5'h00, 8'h12);
        wr("R4", 5'h09, 8'h00);
        ticks("R4", 20, 5'h00);
        // R3: writes to hundredths ignored, no reset of the count
        ticks("R3", 7, 5'h1F);
        wr("R3", 5'h1F, 8'h55);
        rd("R3", 5'h1F);
        read_all("R3");
        // R12: a time write zeroes hundredths
        ticks("R12", 9, 5'h1F);
        wr("R12", 5'h03, 8'h02);
        rd("R12", 5'h1F);
        // R13: reserved bits dropped
        wr("R13", 5'h04, 8'hD5);
        wr("R13", 5'h05, 8'hF2);
        wr("R13", 5'h03, 8'hFB);
        read_all("R13");
        // R7, R10, R8: century toggle with enable, dow 7 -> 1
        wr("R8", 5'h03, 8'h07);
        midnight("R7", 8'hE3, 8'h31, 8'h12, 8'h99);
        // R7: enable clear, bit holds
        midnight("R7", 8'h63, 8'h31, 8'h12, 8'h99);
        // R10: month 12 -> 01 with year step
        midnight("R10", 8'h23, 8'h31, 8'h12, 8'h41);
        // R9: leap February, common February, April, a 31-day month
        midnight("R9", 8'h23, 8'h28, 8'h02, 8'h24);
        midnight("R9", 8'h23, 8'h29, 8'h02, 8'h24);
        midnight("R9", 8'h23, 8'h28, 8'h02, 8'h23);
        midnight("R9", 8'h23, 8'h30, 8'h04, 8'h23);
        midnight("R9", 8'h23, 8'h30, 8'h07, 8'h23);
        // R2: unused addresses read zero
        rd("R2", 5'h08);
        rd("R2", 5'h15);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule